// File: doc/BRIEF.md
# NVRAM Word Fetch Sequencer

This block fetches one 16-bit word from a byte-wide nonvolatile store. The store can only be reached through two 8-bit registers: a command register and a data register. The store also reports a busy flag in the command register. A client raises a request with an address. The sequencer adds a fixed user-region offset to that address. It then reads two consecutive bytes and returns them as a single word, with a one-cycle completion pulse.

Each byte costs six register accesses. Three of them are command writes: select the low address byte, select the high address byte, and begin a read. The sequencer writes the two address bytes to the data register and finally reads the data register. After every one of these accesses, it reads the command register again and again until the busy bit is clear. If the busy bit never clears within a configurable number of polls, the sequencer abandons the request and reports an error.

The register side is a plain valid/ready master. It drives a write-enable, a register-select bit and an 8-bit write bus, and it samples an 8-bit read bus when the handshake completes.

Top module: `nvw_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `bus_valid`, `resp_done` and `resp_err` are 0.
- R2: Every command-register write (`bus_we`=1, `bus_sel`=0) carries an opcode in bits 7:5 with bits 4:0 zero. The opcodes are 3'b100 (take low address byte), 3'b101 (take high address byte) and 3'b111 (start read).
- R3: For each byte, the non-poll accesses come in this order: command 0x80, data write of the address low byte, command 0xA0, data write of the address high byte, command 0xE0, then a data-register read (`bus_we`=0, `bus_sel`=1). A successful request makes exactly 12 such accesses.
- R4: Each non-poll access is followed by reads of the command register (`bus_we`=0, `bus_sel`=0). These reads repeat while the returned bit 7 is 1. The next non-poll access begins only after a read returns bit 7 = 0.
- R5: The byte read for address A forms `resp_data[7:0]` and the byte read for address A+1 forms `resp_data[15:8]`.
- R6: The address used on the register side is `req_addr` + 0x100, and the second byte is at that value + 1. Both sums wrap modulo 2^16.
- R7: A request is taken only while `req_ready` is 1. While a request is in progress, `req_ready` stays 0 and `req_start` and `req_addr` have no effect.
- R8: `resp_done` is high for exactly one cycle per request, and `resp_data` is valid in that same cycle. On success, `resp_err` is 0 and `resp_done` follows a poll that returned bit 7 = 0.
- R9: If POLL_LIMIT (when nonzero) consecutive polls return busy, the sequencer pulses `resp_done` together with `resp_err`, returns `resp_data` = 0, and goes back to idle. POLL_LIMIT-1 busy polls followed by a clear poll do not cause an error.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, `bus_valid`, `bus_we`, `bus_sel` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only when `req_ready` is 1 |
| req_addr | input | ADDR_W | Word address before the user-region offset |
| req_ready | output | 1 | Sequencer is idle and can take a request |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_data | output | 8*WORD_BYTES | Assembled word, valid while `resp_done` is 1 |
| resp_err | output | 1 | Busy-poll timeout, pulses with `resp_done` |
| bus_valid | output | 1 | Register access request |
| bus_ready | input | 1 | Register side accepts the access this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 0 = command register, 1 = data register |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled on a read handshake |

## Verification
A wrong step counter or opcode shows up at the register port on the very next handshake: the bench's register model compares every non-poll access against the sequence it computes from the request address. A poll loop that gives up too early or continues too long shows up one access later, as a non-poll access arriving while the model still reports busy. A wrong lane select or a wrong address sum stays hidden until `resp_done`, when the word is compared against bytes derived from the model's latched address. The timeout counter is tested one poll either side of its limit, and an error is visible in the same cycle as the done pulse.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_POLL   = 2'd2
   } nvw_state_e;

   localparam logic SEL_CMD  = 1'b0;
   localparam logic SEL_DATA = 1'b1;

   localparam logic [2:0] OP_TAKE_LO = 3'b100;
   localparam logic [2:0] OP_TAKE_HI = 3'b101;
   localparam logic [2:0] OP_FETCH   = 3'b111;

   localparam int         BUSY_BIT    = 7;
   localparam int         BYTE_W      = 8;
   localparam logic [2:0] STEP_FETCH  = 3'd5;

   typedef struct packed {
      logic             we;
      logic             sel;
      logic [BYTE_W-1:0] wdata;
   } nvw_access_t;

endpackage

// File: rtl/nvw_step_decode.sv
module nvw_step_decode
   import nvw_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [2:0]        step,
   input  logic [ADDR_W-1:0] byte_addr,
   output nvw_access_t       acc
);

   always_comb begin
      unique case (step)
         3'd0:    acc = '{we: 1'b1, sel: SEL_CMD,  wdata: {OP_TAKE_LO, 5'b0}};
         3'd1:    acc = '{we: 1'b1, sel: SEL_DATA, wdata: byte_addr[7:0]};
         3'd2:    acc = '{we: 1'b1, sel: SEL_CMD,  wdata: {OP_TAKE_HI, 5'b0}};
         3'd3:    acc = '{we: 1'b1, sel: SEL_DATA, wdata: byte_addr[15:8]};
         3'd4:    acc = '{we: 1'b1, sel: SEL_CMD,  wdata: {OP_FETCH, 5'b0}};
         default: acc = '{we: 1'b0, sel: SEL_DATA, wdata: 8'h00};
      endcase
   end

endmodule

// File: rtl/nvw_poll_timer.sv
module nvw_poll_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic busy_hit,
   output logic expire
);

   if (LIMIT == 0) begin : g_no_timeout
      logic unused_timer_ins;
      assign unused_timer_ins = ^{clk, rst_n, clr, busy_hit};
      assign expire = 1'b0;
   end else begin : g_timeout
      localparam int CNT_W = $clog2(LIMIT + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)        cnt_q <= '0;
         else if (clr)      cnt_q <= '0;
         else if (busy_hit) cnt_q <= cnt_q + CNT_W'(1);
      end

      assign expire = busy_hit && (cnt_q == CNT_W'(LIMIT - 1));
   end

endmodule

// File: rtl/nvw_word_asm.sv
module nvw_word_asm #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   parameter int IDX_W  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    cap,
   input  logic [IDX_W-1:0]        lane,
   input  logic [LANE_W-1:0]       din,
   output logic [LANES*LANE_W-1:0] word
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            word[i*LANE_W +: LANE_W] <= '0;
         else if (clr)
            word[i*LANE_W +: LANE_W] <= '0;
         else if (cap && (lane == IDX_W'(i)))
            word[i*LANE_W +: LANE_W] <= din;
      end
   end

endmodule

// File: rtl/nvw_reader.sv
module nvw_reader
   import nvw_pkg::*;
#(
   parameter int              ADDR_W     = 16,
   parameter int              WORD_BYTES = 2,
   parameter logic [15:0]     USER_BASE  = 16'h0100,
   parameter int              POLL_LIMIT = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_start,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    req_ready,
   output logic                    resp_done,
   output logic [8*WORD_BYTES-1:0] resp_data,
   output logic                    resp_err,
   output logic                    bus_valid,
   input  logic                    bus_ready,
   output logic                    bus_we,
   output logic                    bus_sel,
   output logic [7:0]              bus_wdata,
   input  logic [7:0]              bus_rdata
);

   localparam int WORD_W     = 8 * WORD_BYTES;
   localparam int LANE_IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

   if (ADDR_W != 16) begin : g_bad_addr_w
      $error("nvw_reader: address must be two bytes wide");
   end
   if (WORD_BYTES < 1) begin : g_bad_word
      $error("nvw_reader: WORD_BYTES must be at least 1");
   end
   if (POLL_LIMIT < 0) begin : g_bad_limit
      $error("nvw_reader: POLL_LIMIT must not be negative");
   end

   nvw_state_e            state_q;
   logic [2:0]            step_q;
   logic [LANE_IDX_W-1:0] lane_q;
   logic [ADDR_W-1:0]     base_q;
   logic                  done_q;
   logic                  err_q;
   logic [WORD_W-1:0]     data_q;

   logic [ADDR_W-1:0]     byte_addr;
   nvw_access_t           acc;
   logic                  xfer;
   logic                  poll_busy;
   logic                  expire;
   logic                  cap;
   logic                  accept;
   logic                  last_lane;
   logic [WORD_W-1:0]     word;

   assign byte_addr = base_q + ADDR_W'(lane_q);
   assign last_lane = (lane_q == LANE_IDX_W'(WORD_BYTES - 1));
   assign accept    = (state_q == ST_IDLE) && req_start;

   nvw_step_decode #(.ADDR_W(ADDR_W)) u_decode (
      .step      (step_q),
      .byte_addr (byte_addr),
      .acc       (acc)
   );

   assign bus_valid = (state_q != ST_IDLE);
   assign bus_we    = (state_q == ST_ACCESS) && acc.we;
   assign bus_sel   = (state_q == ST_ACCESS) ? acc.sel   : SEL_CMD;
   assign bus_wdata = (state_q == ST_ACCESS) ? acc.wdata : 8'h00;

   assign xfer      = bus_valid && bus_ready;
   assign poll_busy = (state_q == ST_POLL) && xfer && bus_rdata[BUSY_BIT];
   assign cap       = (state_q == ST_ACCESS) && xfer && (step_q == STEP_FETCH);

   nvw_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (state_q != ST_POLL),
      .busy_hit (poll_busy),
      .expire   (expire)
   );

   nvw_word_asm #(
      .LANES  (WORD_BYTES),
      .LANE_W (8),
      .IDX_W  (LANE_IDX_W)
   ) u_asm (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .cap   (cap),
      .lane  (lane_q),
      .din   (bus_rdata),
      .word  (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         lane_q  <= '0;
         base_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_start) begin
                  base_q  <= req_addr + ADDR_W'(USER_BASE);
                  step_q  <= '0;
                  lane_q  <= '0;
                  state_q <= ST_ACCESS;
               end
            end
            ST_ACCESS: begin
               if (bus_ready) state_q <= ST_POLL;
            end
            ST_POLL: begin
               if (bus_ready) begin
                  if (bus_rdata[BUSY_BIT]) begin
                     if (expire) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        data_q  <= '0;
                     end
                  end else if (step_q == STEP_FETCH) begin
                     if (last_lane) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        data_q  <= word;
                     end else begin
                        lane_q  <= lane_q + LANE_IDX_W'(1);
                        step_q  <= '0;
                        state_q <= ST_ACCESS;
                     end
                  end else begin
                     step_q  <= step_q + 3'd1;
                     state_q <= ST_ACCESS;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign resp_done = done_q;
   assign resp_err  = err_q;
   assign resp_data = data_q;

endmodule

// File: rtl/nvw_reader_chk.sv
module nvw_reader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       resp_done,
   input logic       resp_err,
   input logic       bus_valid,
   input logic       bus_ready,
   input logic       bus_we,
   input logic       bus_sel,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata
);

   p_hold_payload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) && $stable(bus_sel) && $stable(bus_wdata));

   p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_we && !bus_sel |-> (bus_wdata == 8'h80 || bus_wdata == 8'hA0 || bus_wdata == 8'hE0));

   p_poll_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && (bus_we || bus_sel) |=> bus_valid && !bus_we && !bus_sel);

   p_busy_repolls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && !bus_we && !bus_sel && bus_rdata[7]
      |=> (bus_valid && !bus_we && !bus_sel) || resp_err);

   p_busy_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);

   p_done_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done && !resp_err |-> $past(bus_valid && bus_ready && !bus_we && !bus_sel && !bus_rdata[7]));

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_err |-> resp_done && req_ready);

endmodule

bind nvw_reader nvw_reader_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .resp_done (resp_done),
   .resp_err  (resp_err),
   .bus_valid (bus_valid),
   .bus_ready (bus_ready),
   .bus_we    (bus_we),
   .bus_sel   (bus_sel),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata)
);

// File: tb/nvw_reader_test.sv
module nvw_reader_test;

   localparam int LIMIT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_ready;
   logic        resp_done;
   logic [15:0] resp_data;
   logic        resp_err;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic        bus_we;
   logic        bus_sel;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata = '0;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 0;

   // register model state
   int          k = 0;
   logic [15:0] exp_base = '0;
   int          busy_cfg = 0;
   int          busy_left = 0;
   bit          poll_pending = 0;
   int          ready_pct = 100;
   logic [7:0]  m_lo = '0, m_hi = '0;
   logic [2:0]  m_op = '0;
   bit          prev_stall = 0;
   logic [9:0]  prev_payload = '0;

   always #10 clk = ~clk;

   nvw_reader #(.POLL_LIMIT(LIMIT)) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_ready(req_ready), .resp_done(resp_done), .resp_data(resp_data),
      .resp_err(resp_err), .bus_valid(bus_valid), .bus_ready(bus_ready),
      .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
   endfunction

   // expected non-poll access {we, sel, wdata} number idx for a base address
   function automatic logic [9:0] exp_acc(input logic [15:0] base, input int idx);
      logic [15:0] a;
      a = base + 16'(idx / 6);
      case (idx % 6)
         0: return {1'b1, 1'b0, 8'h80};
         1: return {1'b1, 1'b1, a[7:0]};
         2: return {1'b1, 1'b0, 8'hA0};
         3: return {1'b1, 1'b1, a[15:8]};
         4: return {1'b1, 1'b0, 8'hE0};
         default: return {1'b0, 1'b1, 8'h00};
      endcase
   endfunction

   function automatic string step_req(input int idx);
      case (idx % 6)
         0, 2, 4: return "R2";
         1, 3:    return "R6";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // register-side model
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ready = 1'b0;
         prev_stall = 0;
      end else begin
         if (prev_stall) begin
            chk(bus_valid && ({bus_we, bus_sel, bus_wdata} == prev_payload), "R10",
                {21'b0, bus_valid, bus_we, bus_sel, bus_wdata}, {21'b0, 1'b1, prev_payload});
         end
         bus_rdata = 8'($urandom);
         if (bus_valid && ($urandom_range(99) < ready_pct)) begin
            bus_ready = 1'b1;
            prev_stall = 0;
            if (!bus_we && !bus_sel) begin
               if (busy_left > 0) begin
                  bus_rdata = 8'h80 | 8'($urandom_range(127));
                  busy_left--;
               end else begin
                  bus_rdata = 8'($urandom_range(127));
                  poll_pending = 0;
               end
            end else begin
               logic [9:0] e;
               e = exp_acc(exp_base, k);
               chk(!poll_pending, "R4", 32'(poll_pending), 0);
               chk(k < 12, "R3", k, 11);
               if (e[9])
                  chk({bus_we, bus_sel, bus_wdata} == e, step_req(k), {bus_we, bus_sel, bus_wdata}, e);
               else
                  chk({bus_we, bus_sel} == e[9:8], "R3", {bus_we, bus_sel}, e[9:8]);
               if (bus_we && !bus_sel) m_op = bus_wdata[7:5];
               else if (bus_we && bus_sel) begin
                  if (m_op == 3'b100) m_lo = bus_wdata;
                  else if (m_op == 3'b101) m_hi = bus_wdata;
               end else if (!bus_we && bus_sel) bus_rdata = memf({m_hi, m_lo});
               k++;
               poll_pending = 1;
               busy_left = busy_cfg;
            end
         end else begin
            bus_ready = 1'b0;
            prev_stall = bus_valid;
            prev_payload = {bus_we, bus_sel, bus_wdata};
         end
      end
   end

   task automatic run_read(input logic [15:0] a, input int bcfg, input bit exp_err, input bit poke);
      int cyc;
      logic [15:0] b;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      b = a + 16'h0100;
      exp_base = b; k = 0; poll_pending = 0; busy_cfg = bcfg; busy_left = 0;
      req_addr = a; req_start = 1'b1;
      @(negedge clk);
      chk(!req_ready, "R7", 32'(req_ready), 0);
      if (poke) req_addr = ~a; else req_start = 1'b0;
      cyc = 0;
      while (!resp_done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (poke && !resp_done && cyc == 5) chk(!req_ready, "R7", 32'(req_ready), 0);
      end
      req_start = 1'b0;
      if (!resp_done) begin
         chk(0, "R8", 0, 1);
      end else begin
         chk(resp_err == exp_err, "R9", 32'(resp_err), 32'(exp_err));
         if (exp_err) begin
            chk(resp_data == 16'h0, "R9", resp_data, 0);
            chk(k == 1, "R9", k, 1);
         end else begin
            chk(resp_data == {memf(b + 16'd1), memf(b)}, "R5", resp_data, {memf(b + 16'd1), memf(b)});
            chk(k == 12, "R3", k, 12);
         end
         @(negedge clk);
         chk(!resp_done, "R8", 32'(resp_done), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(req_ready && !bus_valid && !resp_done && !resp_err, "R1",
          {req_ready, bus_valid, resp_done, resp_err}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !bus_valid && !resp_done && !resp_err, "R1",
          {req_ready, bus_valid, resp_done, resp_err}, 4'b1000);

      // directed: plain read, no busy, always ready
      ready_pct = 100;
      run_read(16'h0000, 0, 0, 0);
      // directed: wrap of offset and of the second byte (R6)
      run_read(16'hFEFF, 1, 0, 0);
      run_read(16'hFF00, 0, 0, 0);
      // directed: request held high with changing address while in progress (R7)
      ready_pct = 60;
      run_read(16'h1234, 2, 0, 1);
      // directed: timeout one below and at the limit (R9)
      ready_pct = 100;
      run_read(16'h00A5, LIMIT - 1, 0, 0);
      run_read(16'h00A6, LIMIT, 1, 0);
      // recovery after timeout
      run_read(16'h5A5A, 0, 0, 0);
      // random mix
      for (int i = 0; i < 40; i++) begin
         ready_pct = 30 + $urandom_range(70);
         run_read(16'($urandom), $urandom_range(3), 0, ($urandom_range(3) == 0));
      end
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end

endmodule